// File: doc/BRIEF.md
# Virtual Address Region Checker

This block sorts every 32-bit virtual address presented by a core into one of three outcomes: it goes straight to the physical bus, it goes to the translation buffers, or it is stopped with an address error. The decision depends on the top address bits, the access kind (load, store or instruction fetch), whether the core runs privileged, whether address translation is switched on, and a lock bit that bars user code from the store-queue window. The block has no state, so a core can place it directly in its address stage.

The same address also drives a store-queue flush target generator. With translation off, the burst target is built from the queue's line offset and a three-bit high-address field chosen per queue by address bit 5. With translation on, the target is the physical address returned by the translation path, with its low five bits cleared so the burst starts on a 32-byte boundary.

Top module: `vaddr_region_chk`

## Requirements
- R1: A privileged load or store at 0xE0000000 or above bypasses translation, and the physical address equals the virtual address.
- R2: A privileged load, store or fetch in 0x80000000..0xBFFFFFFF bypasses translation, and the physical address is the virtual address with bits 31:29 cleared.
- R3: Any access that is allowed and not covered by R1, R2 or R4 (bit 31 clear, 0xC0000000..0xDFFFFFFF when privileged, and privileged fetches at 0xFFFFFF00 and above) requests translation when translation is on. When translation is off it bypasses with bits 31:29 cleared.
- R4: A user load or store with bit 31 set is an address error. The exception is 0xE0000000..0xE3FFFFFF with the store-queue lock bit at 0, which bypasses with the address unchanged.
- R5: The fault code is 2'b10 for a faulting store, 2'b01 for a faulting load or fetch (access kind 2'b11 counts as a load), and 2'b00 whenever there is no fault. Access kinds are 2'b00 load, 2'b01 store and 2'b10 fetch.
- R6: A privileged fetch in 0xE0000000..0xFFFFFEFF is an address error.
- R7: A user fetch with bit 31 set is an address error whatever the other control bits are.
- R8: Exactly one of bypass, translate and fault is high. The physical address output is zero unless bypass is high.
- R9: With translation off, the flush target is {3'b000, qbase[va[5]], va[25:5], 5'b00000}, where qbase[i] is bits 3i+2..3i of the queue base input.
- R10: With translation on, the flush target is the translated physical address input with bits 4:0 forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| va | input | 32 | Virtual address under test |
| acc_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 load |
| priv | input | 1 | Core runs privileged |
| xlat_on | input | 1 | Address translation enabled |
| sq_user_lock | input | 1 | 1 bars user access to the store-queue window |
| qbase_flat | input | 6 | Per-queue high field, queue i at bits 3i+2..3i |
| xlat_pa | input | 32 | Physical address from the translation path |
| pa_out | output | 32 | Physical address on bypass, else zero |
| route_bypass | output | 1 | Access skips translation |
| route_xlat | output | 1 | Access needs translation |
| fault | output | 1 | Address error |
| fault_code | output | 2 | 01 load/fetch error, 10 store error, 00 none |
| sq_target | output | 32 | Store-queue flush burst address |

## Verification
Region classification and flush target generation are produced together for every address, so a single vector is checked on both the route and the flush target. The sweep covers every value of the top address byte with several low-part patterns, including addresses inside the store-queue window where a user store may bypass while its flush target also changes with bit 5. Every combination of access kind, privilege, translation enable and lock bit is applied. For each vector the bench computes the expected route, physical address, fault code and flush target, and compares them with the outputs.

// File: rtl/vreg_pkg.sv
package vreg_pkg;
   typedef enum logic [1:0] {
      ACC_LOAD  = 2'b00,
      ACC_STORE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_ALT   = 2'b11
   } acc_e;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'b00,
      FLT_LOAD  = 2'b01,
      FLT_STORE = 2'b10
   } flt_e;

   typedef enum logic [1:0] {
      RT_BYPASS = 2'b00,
      RT_XLAT   = 2'b01,
      RT_FAULT  = 2'b10
   } route_e;
endpackage

// File: rtl/vreg_region_decode.sv
module vreg_region_decode
   import vreg_pkg::*;
#(
   parameter int          AW            = 32,
   parameter int          PHYS_W        = 29,
   parameter int          SQ_WIN_LSB    = 26,
   parameter logic [31:0] FETCH_HOLE_END = 32'hFFFF_FF00
) (
   input  logic [AW-1:0] va,
   input  acc_e          kind,
   input  logic          priv,
   input  logic          xlat_on,
   input  logic          sq_lock,
   output route_e        route,
   output logic [AW-1:0] pa
);
   localparam logic [AW-1:0] PHYS_MASK = AW'((64'd1 << PHYS_W) - 64'd1);
   localparam int            SQ_TAG_W  = AW - SQ_WIN_LSB;
   localparam logic [SQ_TAG_W-1:0] SQ_TAG = SQ_TAG_W'(6'b111000 >> (6 - SQ_TAG_W));

   generate
      if (AW != 32) begin : g_bad_aw
         $fatal(1, "vreg_region_decode: region map needs AW == 32");
      end
      if (PHYS_W >= AW || PHYS_W < 16) begin : g_bad_phys
         $fatal(1, "vreg_region_decode: PHYS_W out of range");
      end
      if (SQ_WIN_LSB < PHYS_W - 3 || SQ_WIN_LSB > AW - 3) begin : g_bad_sq
         $fatal(1, "vreg_region_decode: store-queue window must lie inside the top segment");
      end
   endgenerate

   logic [2:0]    seg;
   logic          upper;
   logic          top_seg;
   logic          in_sq;
   logic          fetch_hole;
   logic [AW-1:0] masked;
   route_e        tom_route;

   always_comb begin
      seg        = va[AW-1 -: 3];
      upper      = va[AW-1];
      top_seg    = (seg == 3'b111);
      in_sq      = (va[AW-1 -: SQ_TAG_W] == SQ_TAG);
      fetch_hole = top_seg && (va < FETCH_HOLE_END);
      masked     = va & PHYS_MASK;
      tom_route  = xlat_on ? RT_XLAT : RT_BYPASS;
   end

   always_comb begin
      route = RT_FAULT;
      pa    = '0;
      if (!upper) begin
         route = tom_route;
         pa    = masked;
      end else if (kind == ACC_FETCH) begin
         if (!priv || fetch_hole) begin
            route = RT_FAULT;
         end else if (!seg[1]) begin
            route = RT_BYPASS;
            pa    = masked;
         end else begin
            route = tom_route;
            pa    = masked;
         end
      end else if (!priv) begin
         if (in_sq && !sq_lock) begin
            route = RT_BYPASS;
            pa    = va;
         end
      end else if (top_seg) begin
         route = RT_BYPASS;
         pa    = va;
      end else if (!seg[1]) begin
         route = RT_BYPASS;
         pa    = masked;
      end else begin
         route = tom_route;
         pa    = masked;
      end
   end

   always_comb begin
      if (priv && upper && kind == ACC_FETCH && fetch_hole)
         assert_fetch_hole_R6: assert (route == RT_FAULT)
            else $error("privileged fetch in reserved top range not faulted");
      if (!priv && upper && kind == ACC_FETCH)
         assert_user_fetch_R7: assert (route == RT_FAULT)
            else $error("user fetch in upper half not faulted");
   end
endmodule

// File: rtl/vreg_sq_target.sv
module vreg_sq_target #(
   parameter int AW     = 32,
   parameter int NQ     = 2,
   parameter int QHI_W  = 3,
   parameter int LINE_B = 5,
   parameter int SPAN_B = 26
) (
   input  logic [AW-1:0]       va,
   input  logic                xlat_on,
   input  logic [NQ*QHI_W-1:0] qbase_flat,
   input  logic [AW-1:0]       xlat_pa,
   output logic [AW-1:0]       target
);
   localparam int PAD_W = AW - SPAN_B - QHI_W;

   generate
      if (PAD_W < 0) begin : g_bad_span
         $fatal(1, "vreg_sq_target: span plus queue field exceeds AW");
      end
      if (NQ < 1 || (NQ & (NQ - 1)) != 0) begin : g_bad_nq
         $fatal(1, "vreg_sq_target: NQ must be a power of two");
      end
   endgenerate

   logic [QHI_W-1:0] qarr [NQ];
   logic [QHI_W-1:0] qhi;

   generate
      for (genvar q = 0; q < NQ; q++) begin : g_unpack
         assign qarr[q] = qbase_flat[q*QHI_W +: QHI_W];
      end
      if (NQ == 1) begin : g_single
         assign qhi = qarr[0];
      end else begin : g_multi
         localparam int QSEL_W = $clog2(NQ);
         assign qhi = qarr[va[LINE_B +: QSEL_W]];
      end
   endgenerate

   logic [AW-1:0] off_target;
   logic [AW-1:0] on_target;

   always_comb begin
      off_target = {{PAD_W{1'b0}}, qhi, va[SPAN_B-1:LINE_B], {LINE_B{1'b0}}};
      on_target  = {xlat_pa[AW-1:LINE_B], {LINE_B{1'b0}}};
      target     = xlat_on ? on_target : off_target;
   end

   always_comb begin
      if (!xlat_on)
         assert_offset_kept_R9: assert (target[SPAN_B-1:LINE_B] == va[SPAN_B-1:LINE_B])
            else $error("flush target lost the line offset");
   end
endmodule

// File: rtl/vaddr_region_chk.sv
module vaddr_region_chk
   import vreg_pkg::*;
#(
   parameter int AW     = 32,
   parameter int PHYS_W = 29,
   parameter int NQ     = 2,
   parameter int QHI_W  = 3,
   parameter int LINE_B = 5,
   parameter int SPAN_B = 26
) (
   input  logic [AW-1:0]       va,
   input  logic [1:0]          acc_kind,
   input  logic                priv,
   input  logic                xlat_on,
   input  logic                sq_user_lock,
   input  logic [NQ*QHI_W-1:0] qbase_flat,
   input  logic [AW-1:0]       xlat_pa,
   output logic [AW-1:0]       pa_out,
   output logic                route_bypass,
   output logic                route_xlat,
   output logic                fault,
   output logic [1:0]          fault_code,
   output logic [AW-1:0]       sq_target
);
   acc_e          kind;
   route_e        route;
   logic [AW-1:0] dec_pa;

   assign kind = acc_e'(acc_kind);

   vreg_region_decode #(
      .AW     (AW),
      .PHYS_W (PHYS_W)
   ) u_decode (
      .va      (va),
      .kind    (kind),
      .priv    (priv),
      .xlat_on (xlat_on),
      .sq_lock (sq_user_lock),
      .route   (route),
      .pa      (dec_pa)
   );

   vreg_sq_target #(
      .AW     (AW),
      .NQ     (NQ),
      .QHI_W  (QHI_W),
      .LINE_B (LINE_B),
      .SPAN_B (SPAN_B)
   ) u_sqt (
      .va         (va),
      .xlat_on    (xlat_on),
      .qbase_flat (qbase_flat),
      .xlat_pa    (xlat_pa),
      .target     (sq_target)
   );

   flt_e code;

   always_comb begin
      route_bypass = (route == RT_BYPASS);
      route_xlat   = (route == RT_XLAT);
      fault        = (route == RT_FAULT);
      pa_out       = route_bypass ? dec_pa : '0;
      if (!fault)                  code = FLT_NONE;
      else if (kind == ACC_STORE)  code = FLT_STORE;
      else                         code = FLT_LOAD;
      fault_code = code;
   end

   always_comb begin
      if (fault)
         assert_code_set_R5: assert (fault_code != 2'b00)
            else $error("fault without a code");
      if (route_bypass && !va[AW-1])
         assert_low_masked_R3: assert (pa_out[AW-1:PHYS_W] == '0)
            else $error("lower-half bypass kept high bits");
      if (route_xlat)
         assert_xlat_needs_on_R3: assert (xlat_on)
            else $error("translate request with translation off");
      if (xlat_on)
         assert_sq_aligned_R10: assert (sq_target[LINE_B-1:0] == '0)
            else $error("flush target not line aligned");
   end
endmodule

// File: tb/vaddr_region_chk_bench.sv
module vaddr_region_chk_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] va;
   logic [1:0]  acc_kind;
   logic        priv, xlat_on, sq_user_lock;
   logic [5:0]  qbase_flat;
   logic [31:0] xlat_pa;
   logic [31:0] pa_out, sq_target;
   logic        route_bypass, route_xlat, fault;
   logic [1:0]  fault_code;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   vaddr_region_chk u_vaddr_region_chk (
      .va(va), .acc_kind(acc_kind), .priv(priv), .xlat_on(xlat_on),
      .sq_user_lock(sq_user_lock), .qbase_flat(qbase_flat), .xlat_pa(xlat_pa),
      .pa_out(pa_out), .route_bypass(route_bypass), .route_xlat(route_xlat),
      .fault(fault), .fault_code(fault_code), .sq_target(sq_target)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s va=%h kind=%0d priv=%0b xo=%0b lock=%0b act=%h exp=%h",
                  tag, va, acc_kind, priv, xlat_on, sq_user_lock, act, exp);
      end
   endtask

   // route: 0 bypass, 1 translate, 2 fault
   task automatic model(input logic [31:0] a, input logic [1:0] k, input logic p,
                        input logic xo, input logic lk,
                        output int rt, output logic [31:0] pa, output string tag);
      logic [31:0] m;
      m = a & 32'h1FFF_FFFF;
      rt = 2; pa = 32'h0; tag = "R3";
      if (!a[31]) begin
         tag = "R3"; rt = xo ? 1 : 0; pa = m;
      end else if (k == 2'b10) begin
         if (!p) begin tag = "R7"; rt = 2; end
         else if (a < 32'hC000_0000) begin tag = "R2"; rt = 0; pa = m; end
         else if (a >= 32'hE000_0000 && a < 32'hFFFF_FF00) begin tag = "R6"; rt = 2; end
         else begin tag = "R3"; rt = xo ? 1 : 0; pa = m; end
      end else if (!p) begin
         tag = "R4";
         if (a >= 32'hE000_0000 && a < 32'hE400_0000 && !lk) begin rt = 0; pa = a; end
      end else if (a >= 32'hE000_0000) begin
         tag = "R1"; rt = 0; pa = a;
      end else if (a < 32'hC000_0000) begin
         tag = "R2"; rt = 0; pa = m;
      end else begin
         tag = "R3"; rt = xo ? 1 : 0; pa = m;
      end
      if (rt != 0) pa = 32'h0;
   endtask

   task automatic run_vec(input logic [31:0] a, input logic [1:0] k, input logic p,
                          input logic xo, input logic lk);
      int          rt;
      logic [31:0] epa, esq;
      logic [1:0]  ecode;
      logic [2:0]  qsel;
      string       tag;
      va = a; acc_kind = k; priv = p; xlat_on = xo; sq_user_lock = lk;
      xlat_pa = a ^ 32'h5A5A_5A5F;
      #2;
      model(a, k, p, xo, lk, rt, epa, tag);
      chk(tag, {route_xlat, route_bypass, fault, pa_out[28:0]},
          {rt == 1, rt == 0, rt == 2, epa[28:0]});
      chk(tag, pa_out, epa);
      // R8: exactly one route flag
      chk("R8", 32'(route_bypass) + 32'(route_xlat) + 32'(fault), 32'd1);
      // R5: fault code
      ecode = (rt != 2) ? 2'b00 : (k == 2'b01 ? 2'b10 : 2'b01);
      chk("R5", 32'(fault_code), 32'(ecode));
      if (xo) begin
         esq = {xlat_pa[31:5], 5'b0};
         chk("R10", sq_target, esq);
      end else begin
         qsel = a[5] ? qbase_flat[5:3] : qbase_flat[2:0];
         esq = {3'b000, qsel, a[25:5], 5'b0};
         chk("R9", sq_target, esq);
      end
   endtask

   initial begin
      #(50000 * 10);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [23:0] lows [5];
      lows[0] = 24'h00_0000; lows[1] = 24'hFF_FFFF; lows[2] = 24'h12_3460;
      lows[3] = 24'hFF_FEFF; lows[4] = 24'hFF_FF00;
      va = '0; acc_kind = '0; priv = 1'b0; xlat_on = 1'b0; sq_user_lock = 1'b0;
      qbase_flat = {3'b010, 3'b101}; xlat_pa = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // idle state: zero address, user load, translation off -> plain bypass (R3)
      chk("R3", {29'b0, route_bypass, route_xlat, fault}, 32'b100);
      chk("R3", pa_out, 32'h0);
      for (int hb = 0; hb < 256; hb++) begin
         for (int lp = 0; lp < 5; lp++) begin
            for (int c = 0; c < 32; c++) begin
               qbase_flat = (hb[0]) ? {3'b010, 3'b101} : {3'b111, 3'b001};
               run_vec({hb[7:0], lows[lp]}, c[1:0], c[2], c[3], c[4]);
            end
         end
      end
      // store-queue window edges for a user store
      run_vec(32'hE3FF_FFE0, 2'b01, 1'b0, 1'b0, 1'b0);
      run_vec(32'hE400_0000, 2'b01, 1'b0, 1'b0, 1'b0);
      run_vec(32'hE000_0020, 2'b01, 1'b0, 1'b1, 1'b1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule